// File: doc/BRIEF.md
# Receive Link Monitor with Latching Status

This block decides whether a receive link is usable. It combines a level-sensitive signal-detect input with a lock indication from the receive clock-recovery loop. A link counts as good only after both inputs have held true for a programmable qualification window. Any loss of either input drops the link on the next clock edge and raises a receive-channel-error output.

The block keeps two status words that a management agent reads through a small port with an address, a read strobe and a data output. The basic word holds a link bit that latches low, so a link drop that has already healed is still reported once. The detailed word holds a live link bit and two bits that latch high: one for loss of lock and one for a premature end of frame reported by the receive framer. A read clears the latched bits of the word that was read. If the condition is still present in that cycle, the bit stays set, so no event is lost.

Top module: `link_monitor`

## Requirements
- R1: `rx_chan_err_o` is 1 one clock edge after a cycle in which `sig_detect_i` or `pll_locked_i` is 0, and 0 one edge after a cycle in which both are 1.
- R2: `link_up_o` becomes 1 only at the QUAL_CYCLES-th consecutive edge at which both `sig_detect_i` and `pll_locked_i` are 1. A single cycle with either input at 0 restarts the count.
- R3: One edge after a cycle in which either input is 0, `link_up_o` is 0. The live link bit in word 17 (bit 0) reads 0 from then on.
- R4: Word 17 bit 9 (lock error) is set at the edge after `pll_locked_i` is sampled 0. It stays set until a read of word 17, and that read returns 1.
- R5: A one-cycle pulse on `early_end_i` sets word 17 bit 5 (premature end). The bit stays set until a read of word 17, and that read returns 1.
- R6: Word 1 bit 2 (basic link) latches low. After the link drops, the next read of word 1 returns 0 even if the link has recovered. Later reads return the live link state, which is sampled one edge later than `link_up_o`.
- R7: If a latch-high condition is present in the same cycle as a read that clears its bit, the bit stays set. The next read returns 1 again.
- R8: `rd_data_o` is loaded at the edge that samples `rd_en_i`=1 with the value of the addressed word before that edge's clear, and holds its value while `rd_en_i` is 0. Unused bits, and addresses other than 1 and 17, read as 0.
- R9: A read of word 1 leaves the latched bits of word 17 unchanged.
- R10: A synchronous reset drives `link_up_o`, `rx_chan_err_o`, `rd_data_o` and all latched bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_detect_i | input | 1 | Receive signal present (level) |
| pll_locked_i | input | 1 | Clock-recovery loop is locked (level) |
| early_end_i | input | 1 | Premature-end pulse from the receive framer |
| rd_en_i | input | 1 | Read strobe for the status port |
| rd_addr_i | input | ADDR_W (5) | Status word address |
| rd_data_o | output | DATA_W (16) | Registered read data |
| rx_chan_err_o | output | 1 | Receive channel error |
| link_up_o | output | 1 | Qualified live link status |

## Verification
`rx_chan_err_o`, the fall of `link_up_o` and `rd_data_o` are all due at the first edge that samples the stimulus. The rise of `link_up_o` is due at the QUAL_CYCLES-th good edge. The basic link latch sees the link one edge after `link_up_o` changes. The bench drives each vector at a falling edge, lets one rising edge pass and compares at the next falling edge. Every expected value is therefore the state after exactly the edge that sampled that vector. The table is ordered so that each latch is read before, during and after the cycle that would set or clear it.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int WORD_BASIC   = 1;
  localparam int WORD_DETAIL  = 17;
  localparam int BASIC_LINK   = 2;
  localparam int DET_LINK     = 0;
  localparam int DET_EARLYEND = 5;
  localparam int DET_LOCKERR  = 9;
endpackage

// File: rtl/lm_qualifier.sv
module lm_qualifier #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_ok_i,
  input  logic lock_i,
  output logic link_o,
  output logic err_o
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic             fault;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign fault = !sig_ok_i || !lock_i;

  always_comb begin
    if (cnt_q == CNT_MAX) cnt_nxt = cnt_q;
    else                  cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      link_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      err_o <= fault;
      if (fault) begin
        cnt_q  <= '0;
        link_o <= 1'b0;
      end else begin
        cnt_q  <= cnt_nxt;
        link_o <= (cnt_nxt == CNT_MAX);
      end
    end
  end

  assert_err_raise_R1: assert property (@(posedge clk) disable iff (rst)
    fault |=> err_o);
  assert_err_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !fault |=> !err_o);
  assert_fault_drops_link_R3: assert property (@(posedge clk) disable iff (rst)
    fault |=> !link_o);
  assert_rise_needs_good_R2: assert property (@(posedge clk) disable iff (rst)
    (!link_o && cnt_q != CNT_MAX - CNT_W'(1)) |=> !link_o);
endmodule

// File: rtl/lm_latch.sv
module lm_latch #(
  parameter bit LATCH_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  input  logic clr_i,
  output logic q_o
);
  generate
    if (LATCH_LOW) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= cond_i && (q_o || clr_i);
      end
      assert_low_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (!q_o && !clr_i) |=> !q_o);
      assert_low_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !cond_i |=> !q_o);
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= cond_i || (q_o && !clr_i);
      end
      assert_high_set_R7: assert property (@(posedge clk) disable iff (rst)
        cond_i |=> q_o);
      assert_high_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);
    end
  endgenerate
endmodule

// File: rtl/lm_readport.sv
module lm_readport #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] basic_word_i,
  input  logic [DATA_W-1:0] detail_word_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import lm_pkg::*;

  logic [DATA_W-1:0] sel;

  always_comb begin
    if (rd_addr_i == ADDR_W'(WORD_BASIC))       sel = basic_word_i;
    else if (rd_addr_i == ADDR_W'(WORD_DETAIL)) sel = detail_word_i;
    else                                        sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= sel;
  end

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/link_monitor.sv
module link_monitor #(
  parameter int QUAL_CYCLES = 16,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_detect_i,
  input  logic              pll_locked_i,
  input  logic              early_end_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_chan_err_o,
  output logic              link_up_o
);
  import lm_pkg::*;

  logic clr_basic, clr_detail;
  logic basic_link_q, lock_err_q, early_end_q;
  logic [DATA_W-1:0] basic_word, detail_word;

  assign clr_basic  = rd_en_i && (rd_addr_i == ADDR_W'(WORD_BASIC));
  assign clr_detail = rd_en_i && (rd_addr_i == ADDR_W'(WORD_DETAIL));

  lm_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .sig_ok_i(sig_detect_i), .lock_i(pll_locked_i),
    .link_o(link_up_o), .err_o(rx_chan_err_o)
  );

  lm_latch #(.LATCH_LOW(1'b1)) u_basic_link (
    .clk(clk), .rst(rst), .cond_i(link_up_o), .clr_i(clr_basic),
    .q_o(basic_link_q)
  );

  lm_latch #(.LATCH_LOW(1'b0)) u_lock_err (
    .clk(clk), .rst(rst), .cond_i(!pll_locked_i), .clr_i(clr_detail),
    .q_o(lock_err_q)
  );

  lm_latch #(.LATCH_LOW(1'b0)) u_early_end (
    .clk(clk), .rst(rst), .cond_i(early_end_i), .clr_i(clr_detail),
    .q_o(early_end_q)
  );

  always_comb begin
    basic_word               = '0;
    basic_word[BASIC_LINK]   = basic_link_q;
    detail_word              = '0;
    detail_word[DET_LINK]    = link_up_o;
    detail_word[DET_EARLYEND] = early_end_q;
    detail_word[DET_LOCKERR] = lock_err_q;
  end

  lm_readport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .basic_word_i(basic_word), .detail_word_i(detail_word),
    .rd_data_o(rd_data_o)
  );

  assert_basic_read_keeps_detail_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_basic && lock_err_q) |=> lock_err_q);
endmodule

// File: tb/tb_link_monitor.sv
module tb_link_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sd = 1'b0, lk = 1'b0, pe = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] rdata;
  logic        err, link;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_monitor #(.QUAL_CYCLES(QUAL), .ADDR_W(5), .DATA_W(16)) dut (
    .clk(clk), .rst(rst), .sig_detect_i(sd), .pll_locked_i(lk),
    .early_end_i(pe), .rd_en_i(rd), .rd_addr_i(addr), .rd_data_o(rdata),
    .rx_chan_err_o(err), .link_up_o(link)
  );

  typedef struct packed {
    logic sd, lk, pe, rd;
    logic [4:0]  addr;
    logic        err, link;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,5'd0, 1'b0,1'b0,16'h0000,4'd2},  // R2 count 1
    '{1'b1,1'b1,1'b0,1'b0,5'd0, 1'b0,1'b0,16'h0000,4'd2},  // R2 count 2
    '{1'b1,1'b1,1'b0,1'b0,5'd0, 1'b0,1'b0,16'h0000,4'd2},  // R2 count 3
    '{1'b1,1'b1,1'b0,1'b0,5'd0, 1'b0,1'b1,16'h0000,4'd2},  // R2 link up
    '{1'b1,1'b1,1'b0,1'b1,5'd1, 1'b0,1'b1,16'h0000,4'd6},  // R6 first read 0
    '{1'b1,1'b1,1'b0,1'b1,5'd1, 1'b0,1'b1,16'h0004,4'd6},  // R6 live
    '{1'b1,1'b1,1'b0,1'b1,5'd17,1'b0,1'b1,16'h0001,4'd3},  // R3 live bit
    '{1'b0,1'b1,1'b0,1'b0,5'd0, 1'b1,1'b0,16'h0001,4'd1},  // R1 no signal
    '{1'b1,1'b1,1'b0,1'b0,5'd0, 1'b0,1'b0,16'h0001,4'd1},  // R1 recovered
    '{1'b1,1'b1,1'b0,1'b1,5'd1, 1'b0,1'b0,16'h0000,4'd6},  // R6 latched low
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,16'h0000,4'd1},  // R1 unlock
    '{1'b1,1'b1,1'b1,1'b0,5'd0, 1'b0,1'b0,16'h0000,4'd5},  // R5 pulse
    '{1'b1,1'b1,1'b0,1'b1,5'd1, 1'b0,1'b0,16'h0000,4'd9},  // R9 other word
    '{1'b1,1'b1,1'b0,1'b1,5'd17,1'b0,1'b0,16'h0220,4'd4},  // R4 R5 latched
    '{1'b1,1'b1,1'b0,1'b1,5'd17,1'b0,1'b1,16'h0000,4'd4},  // R4 cleared
    '{1'b1,1'b1,1'b1,1'b1,5'd17,1'b0,1'b1,16'h0001,4'd7},  // R7 set at read
    '{1'b1,1'b1,1'b0,1'b1,5'd17,1'b0,1'b1,16'h0021,4'd7},  // R7 kept
    '{1'b1,1'b0,1'b0,1'b1,5'd17,1'b1,1'b0,16'h0001,4'd3},  // R3 unlock drop
    '{1'b1,1'b0,1'b0,1'b1,5'd17,1'b1,1'b0,16'h0200,4'd7},  // R7 still present
    '{1'b1,1'b1,1'b0,1'b1,5'd17,1'b0,1'b0,16'h0200,4'd4},  // R4 reads once more
    '{1'b1,1'b1,1'b0,1'b1,5'd3, 1'b0,1'b0,16'h0000,4'd8}   // R8 unmapped
  };

  task automatic check(input int req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic s, input logic l, input logic p,
                      input logic r, input logic [4:0] a);
    sd = s; lk = l; pe = p; rd = r; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset values
    check(10, "reset link", {15'd0, link}, 16'h0);
    check(10, "reset err", {15'd0, err}, 16'h0);
    check(10, "reset rdata", rdata, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].sd, VECS[i].lk, VECS[i].pe, VECS[i].rd, VECS[i].addr);
      check(int'(VECS[i].req), $sformatf("vec %0d err", i), {15'd0, err}, {15'd0, VECS[i].err});
      check(int'(VECS[i].req), $sformatf("vec %0d link", i), {15'd0, link}, {15'd0, VECS[i].link});
      check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), rdata, VECS[i].data);
    end

    // R2: good count resumes from 2, link up at count 4
    step(1, 1, 0, 0, 5'd0);
    check(2, "count 3 link", {15'd0, link}, 16'h0);
    step(1, 1, 0, 0, 5'd0);
    check(2, "count 4 link", {15'd0, link}, 16'h1);
    step(1, 1, 0, 1, 5'd17);
    check(8, "read detail", rdata, 16'h0001);
    // R8 hold while no read, R5 set meanwhile
    step(1, 1, 1, 0, 5'd17);
    check(8, "hold rdata", rdata, 16'h0001);
    step(1, 1, 0, 1, 5'd17);
    check(5, "early end read", rdata, 16'h0021);

    // R10 reset while link up
    rst = 1'b1;
    step(1, 0, 1, 0, 5'd0);
    check(10, "mid reset link", {15'd0, link}, 16'h0);
    check(10, "mid reset err", {15'd0, err}, 16'h0);
    check(10, "mid reset rdata", rdata, 16'h0);
    rst = 1'b0;
    step(1, 1, 0, 1, 5'd17);
    check(10, "latches cleared by reset", rdata, 16'h0000);

    // R2 interrupted qualification (one good cycle already counted)
    step(1, 1, 0, 0, 5'd0);
    step(1, 1, 0, 0, 5'd0);
    check(2, "three good", {15'd0, link}, 16'h0);
    step(0, 1, 0, 0, 5'd0);
    check(2, "interrupt", {15'd0, link}, 16'h0);
    for (int k = 1; k <= QUAL; k++) begin
      step(1, 1, 0, 0, 5'd0);
      check(2, $sformatf("requal %0d", k), {15'd0, link}, (k == QUAL) ? 16'h1 : 16'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule